// File: doc/BRIEF.md
# Extended-Mode Unlock Sequencer

This block sits beside the legacy soft-switch decoder of a disk controller. Each access to one of the sixteen legacy switches arrives as a one-cycle strobe with a switch code, a direction and, for writes, a data byte. The sequencer follows these accesses and looks for the one pattern that moves the controller out of its legacy register set and into its extended one.

The pattern has two parts. First come three precondition accesses. Then come four keyed writes to the Q7-high switch. When the last key byte lands, the block emits a one-cycle enter pulse and raises its extended-mode flag. The extended register logic uses that flag to take over decoding, so that, for example, a written phase value can be read back.

While the flag is up, legacy accesses mean nothing to the sequencer. A strobe from the extended side, produced when software clears mode bit 6, drops the flag. That exit re-arms the sequencer, so the full pattern can be entered again.

Top module: `unlock_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ext_enter` and `ext_active` are 0 and the sequencer is idle.
- R2: Switch codes on `sw_code` are: 0..7 phase lines, 8 motor off, 9 motor on, 10/11 drive selects, 12 Q6 low, 13 Q6 high, 14 Q7 low, 15 Q7 high. The preconditions are three accesses, in this order and of either direction: code 14, then code 8, then code 13.
- R3: After the preconditions, four write strobes to code 15 carrying 0x57, 0x17, 0x57, 0x57, in that order, set `ext_enter` and `ext_active` high in the cycle after the clock edge that samples the fourth write.
- R4: `ext_enter` is high for exactly one cycle per entry.
- R5: A key write whose byte differs from the expected byte at any of the four positions returns the sequencer to idle without entry. A complete pattern issued afterwards still enters.
- R6: If a precondition is missing or out of order, the key writes that follow do not cause entry.
- R7: Any access other than the expected next one aborts to idle. This includes a read of code 15 during the key, a motor-on access (code 9) at any step, and any other switch. The aborting access does not itself count as the first precondition.
- R8: The sequencer moves at most one step per strobe. A cycle with `sw_stb` low changes neither the step nor the outputs.
- R9: While `ext_active` is high, switch accesses have no effect. An `ext_exit` pulse clears `ext_active` in the next cycle and leaves the sequencer idle and ready for a new pattern.
- R10: `ext_exit` has no effect while `ext_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_stb | input | 1 | One-cycle strobe for a legacy soft-switch access |
| sw_write | input | 1 | 1 when the access is a write |
| sw_code | input | 4 | Switch code of the access |
| sw_wdata | input | 8 | Byte written with the access |
| ext_exit | input | 1 | Exit strobe from the extended side (mode bit 6 cleared) |
| ext_enter | output | 1 | One-cycle pulse that sets the extended-mode flag |
| ext_active | output | 1 | Extended mode flag |

## Verification
The exact pattern is applied from reset and again after an exit. This separates a correct re-arm from a sequencer that stays stuck in extended mode. Single corrupted key bytes at each of the four positions show that every position is compared against its own byte, and are told apart from reads of the key switch, which a data-only check would let through. Skipped and swapped preconditions, plus motor-on and stray accesses between steps, exercise the abort path. A long random mix that favours the next expected access, scored against a step-by-step model, reaches partial patterns, back-to-back restarts and exits at arbitrary points.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

    localparam int UNL_SW_W    = 4;
    localparam int UNL_DATA_W  = 8;
    localparam int UNL_PRE_LEN = 3;
    localparam int UNL_KEY_LEN = 4;

    // Precondition switch codes, entry 0 in the low bits: Q7 low, motor off, Q6 high
    localparam logic [UNL_PRE_LEN*UNL_SW_W-1:0] UNL_PRE_CODES = {4'd13, 4'd8, 4'd14};
    // Key bytes, entry 0 in the low bits
    localparam logic [UNL_KEY_LEN*UNL_DATA_W-1:0] UNL_KEY_BYTES =
        {8'h57, 8'h57, 8'h17, 8'h57};
    // Switch that carries the key writes (Q7 high)
    localparam logic [UNL_SW_W-1:0] UNL_KEY_SW = 4'd15;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_PRE  = 2'd1,
        SQ_KEY  = 2'd2,
        SQ_EXT  = 2'd3
    } sq_phase_e;

endpackage

// File: rtl/unlock_swdec.sv
module unlock_swdec #(
    parameter int SW_W    = 4,
    parameter int PRE_LEN = 3,
    parameter int IDX_W   = 2,
    parameter logic [PRE_LEN*SW_W-1:0] PRE_CODES = '0,
    parameter logic [SW_W-1:0] KEY_SW = '1
) (
    input  logic             acc_vld,
    input  logic             acc_wr,
    input  logic [SW_W-1:0]  acc_sw,
    input  logic [IDX_W-1:0] pre_idx,
    output logic             pre_hit,
    output logic             key_slot
);
    logic [PRE_LEN-1:0] code_eq;

    for (genvar gi = 0; gi < PRE_LEN; gi++) begin : g_pre
        assign code_eq[gi] = (acc_sw == PRE_CODES[gi*SW_W +: SW_W]);
    end

    always_comb begin
        pre_hit = 1'b0;
        for (int i = 0; i < PRE_LEN; i++) begin
            if (pre_idx == IDX_W'(i)) pre_hit = acc_vld & code_eq[i];
        end
    end

    assign key_slot = acc_vld & acc_wr & (acc_sw == KEY_SW);

endmodule

// File: rtl/unlock_keymatch.sv
module unlock_keymatch #(
    parameter int DATA_W  = 8,
    parameter int KEY_LEN = 4,
    parameter int IDX_W   = 2,
    parameter logic [KEY_LEN*DATA_W-1:0] KEY_BYTES = '0
) (
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  key_idx,
    output logic              byte_ok,
    output logic              at_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_LEN - 1);

    logic [KEY_LEN-1:0] byte_eq;

    for (genvar gk = 0; gk < KEY_LEN; gk++) begin : g_key
        assign byte_eq[gk] = (wdata == KEY_BYTES[gk*DATA_W +: DATA_W]);
    end

    always_comb begin
        byte_ok = 1'b0;
        for (int i = 0; i < KEY_LEN; i++) begin
            if (key_idx == IDX_W'(i)) byte_ok = byte_eq[i];
        end
    end

    assign at_last = (key_idx == LAST_IDX);

endmodule

// File: rtl/unlock_seq.sv
module unlock_seq
    import unlock_pkg::*;
#(
    parameter int SW_W    = UNL_SW_W,
    parameter int DATA_W  = UNL_DATA_W,
    parameter int PRE_LEN = UNL_PRE_LEN,
    parameter int KEY_LEN = UNL_KEY_LEN,
    parameter logic [PRE_LEN*SW_W-1:0]   PRE_CODES = UNL_PRE_CODES,
    parameter logic [KEY_LEN*DATA_W-1:0] KEY_BYTES = UNL_KEY_BYTES,
    parameter logic [SW_W-1:0]           KEY_SW    = UNL_KEY_SW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_stb,
    input  logic              sw_write,
    input  logic [SW_W-1:0]   sw_code,
    input  logic [DATA_W-1:0] sw_wdata,
    input  logic              ext_exit,
    output logic              ext_enter,
    output logic              ext_active
);
    localparam int MAX_STEPS = (PRE_LEN > KEY_LEN) ? PRE_LEN : KEY_LEN;
    localparam int IDX_W     = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1;
    localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(PRE_LEN - 1);

    typedef struct packed {
        sq_phase_e        phase;
        logic [IDX_W-1:0] idx;
        logic             enter;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic [IDX_W-1:0] pre_idx;
    logic             pre_hit;
    logic             key_slot;
    logic             byte_ok;
    logic             key_last;

    // Idle behaves as precondition step 0
    assign pre_idx = (state_q.phase == SQ_PRE) ? state_q.idx : '0;

    unlock_swdec #(
        .SW_W      (SW_W),
        .PRE_LEN   (PRE_LEN),
        .IDX_W     (IDX_W),
        .PRE_CODES (PRE_CODES),
        .KEY_SW    (KEY_SW)
    ) u_swdec (
        .acc_vld  (sw_stb),
        .acc_wr   (sw_write),
        .acc_sw   (sw_code),
        .pre_idx  (pre_idx),
        .pre_hit  (pre_hit),
        .key_slot (key_slot)
    );

    unlock_keymatch #(
        .DATA_W    (DATA_W),
        .KEY_LEN   (KEY_LEN),
        .IDX_W     (IDX_W),
        .KEY_BYTES (KEY_BYTES)
    ) u_keymatch (
        .wdata   (sw_wdata),
        .key_idx (state_q.idx),
        .byte_ok (byte_ok),
        .at_last (key_last)
    );

    always_comb begin
        state_d       = state_q;
        state_d.enter = 1'b0;
        unique case (state_q.phase)
            SQ_IDLE, SQ_PRE: begin
                if (sw_stb) begin
                    if (pre_hit && pre_idx == PRE_LAST) begin
                        state_d.phase = SQ_KEY;
                        state_d.idx   = '0;
                    end else if (pre_hit) begin
                        state_d.phase = SQ_PRE;
                        state_d.idx   = pre_idx + 1'b1;
                    end else begin
                        state_d.phase = SQ_IDLE;
                        state_d.idx   = '0;
                    end
                end
            end
            SQ_KEY: begin
                if (sw_stb) begin
                    if (key_slot && byte_ok && key_last) begin
                        state_d.phase = SQ_EXT;
                        state_d.idx   = '0;
                        state_d.enter = 1'b1;
                    end else if (key_slot && byte_ok) begin
                        state_d.idx   = state_q.idx + 1'b1;
                    end else begin
                        state_d.phase = SQ_IDLE;
                        state_d.idx   = '0;
                    end
                end
            end
            SQ_EXT: begin
                if (ext_exit) begin
                    state_d.phase = SQ_IDLE;
                    state_d.idx   = '0;
                end
            end
            default: begin
                state_d.phase = SQ_IDLE;
                state_d.idx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.phase <= SQ_IDLE;
            state_q.idx   <= '0;
            state_q.enter <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ext_enter  = state_q.enter;
    assign ext_active = (state_q.phase == SQ_EXT);

endmodule

// File: rtl/unlock_seq_chk.sv
module unlock_seq_chk
    import unlock_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sw_stb,
    input logic                  sw_write,
    input logic [UNL_SW_W-1:0]   sw_code,
    input logic [UNL_DATA_W-1:0] sw_wdata,
    input logic                  ext_exit,
    input logic                  ext_enter,
    input logic                  ext_active
);
    localparam logic [UNL_DATA_W-1:0] LAST_BYTE =
        UNL_KEY_BYTES[(UNL_KEY_LEN-1)*UNL_DATA_W +: UNL_DATA_W];

    a_r4_enter_single: assert property (@(posedge clk) disable iff (!rst_n)
        ext_enter |=> !ext_enter);

    a_r3_enter_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ext_enter |-> (ext_active && !$past(ext_active)));

    a_r3_enter_after_last_key: assert property (@(posedge clk) disable iff (!rst_n)
        ext_enter |-> $past(sw_stb && sw_write && sw_code == UNL_KEY_SW && sw_wdata == LAST_BYTE));

    a_r8_no_strobe_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_stb |=> !ext_enter);

    a_r9_exit_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_active && ext_exit) |=> !ext_active);

    a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_active && !ext_exit) |=> ext_active);

    a_r10_exit_when_legacy: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_active && !sw_stb) |=> !ext_active);

endmodule

bind unlock_seq unlock_seq_chk u_unlock_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_stb     (sw_stb),
    .sw_write   (sw_write),
    .sw_code    (sw_code),
    .sw_wdata   (sw_wdata),
    .ext_exit   (ext_exit),
    .ext_enter  (ext_enter),
    .ext_active (ext_active)
);

// File: tb/tb_unlock_seq.sv
`timescale 1ns/1ps
module tb_unlock_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_stb = 1'b0;
    logic       sw_write = 1'b0;
    logic [3:0] sw_code = '0;
    logic [7:0] sw_wdata = '0;
    logic       ext_exit = 1'b0;
    logic       ext_enter;
    logic       ext_active;

    always #5 clk = ~clk;

    unlock_seq dut (
        .clk(clk), .rst_n(rst_n), .sw_stb(sw_stb), .sw_write(sw_write),
        .sw_code(sw_code), .sw_wdata(sw_wdata), .ext_exit(ext_exit),
        .ext_enter(ext_enter), .ext_active(ext_active)
    );

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;
    int  prog  = 0;   // 0 idle, 1..3 preconditions seen, 4..6 key bytes seen
    bit  m_ext = 0;
    bit  m_ent = 0;

    function automatic logic [3:0] pre_code(input int i);
        case (i)
            0: return 4'd14;
            1: return 4'd8;
            default: return 4'd13;
        endcase
    endfunction

    function automatic logic [7:0] key_byte(input int i);
        return (i == 1) ? 8'h17 : 8'h57;
    endfunction

    // Requirement model of one access
    function automatic void model_access(input logic [3:0] c, input logic w, input logic [7:0] d);
        m_ent = 0;
        if (m_ext) return;
        if (prog < 3) begin
            prog = (c == pre_code(prog)) ? prog + 1 : 0;
        end else begin
            if (w && c == 4'd15 && d == key_byte(prog - 3)) begin
                if (prog == 6) begin
                    m_ext = 1; m_ent = 1; prog = 0;
                end else begin
                    prog = prog + 1;
                end
            end else begin
                prog = 0;
            end
        end
    endfunction

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [3:0] c, input logic w, input logic [7:0] d, input string req);
        @(negedge clk);
        sw_stb = 1'b1; sw_write = w; sw_code = c; sw_wdata = d;
        model_access(c, w, d);
        @(negedge clk);
        sw_stb = 1'b0;
        chk(ext_enter, m_ent, req, "ext_enter");
        chk(ext_active, m_ext, req, "ext_active");
    endtask

    task automatic do_exit(input string req);
        @(negedge clk);
        ext_exit = 1'b1;
        if (m_ext) begin m_ext = 0; prog = 0; end
        @(negedge clk);
        ext_exit = 1'b0;
        chk(ext_active, m_ext, req, "ext_active after exit");
        chk(ext_enter, 1'b0, req, "ext_enter after exit");
    endtask

    task automatic preconds(input string req);
        access(4'd14, 1'b0, 8'h00, req);
        access(4'd8,  1'b0, 8'h00, req);
        access(4'd13, 1'b0, 8'h00, req);
    endtask

    task automatic full_key(input string req);
        for (int i = 0; i < 4; i++) access(4'd15, 1'b1, key_byte(i), req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R8 watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(ext_enter, 1'b0, "R1", "ext_enter in reset");
        chk(ext_active, 1'b0, "R1", "ext_active in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(ext_enter, 1'b0, "R1", "ext_enter after reset");
        chk(ext_active, 1'b0, "R1", "ext_active after reset");

        // R2/R3: exact pattern with mixed directions on preconditions
        access(4'd14, 1'b1, 8'hAA, "R2");
        access(4'd8,  1'b0, 8'h00, "R2");
        access(4'd13, 1'b1, 8'h01, "R2");
        full_key("R3");
        @(negedge clk);
        chk(ext_enter, 1'b0, "R4", "ext_enter one cycle later");
        chk(ext_active, 1'b1, "R4", "ext_active held");

        // R9: accesses ignored in extended mode, then exit and re-entry
        preconds("R9");
        full_key("R9");
        do_exit("R9");
        preconds("R9");
        full_key("R9");
        do_exit("R9");
        // R10: exit while legacy
        do_exit("R10");

        // R5: one wrong byte per position, then full pattern still works
        for (int p = 0; p < 4; p++) begin
            preconds("R5");
            for (int i = 0; i < 4; i++)
                access(4'd15, 1'b1, (i == p) ? (key_byte(i) ^ 8'h01) : key_byte(i), "R5");
        end
        preconds("R5");
        full_key("R5");
        do_exit("R5");

        // R6: missing motor-off precondition, then swapped order
        access(4'd14, 1'b0, 8'h00, "R6");
        access(4'd13, 1'b0, 8'h00, "R6");
        full_key("R6");
        access(4'd8,  1'b0, 8'h00, "R6");
        access(4'd14, 1'b0, 8'h00, "R6");
        access(4'd13, 1'b0, 8'h00, "R6");
        full_key("R6");

        // R7: motor-on mid-key, read of key switch, stray access, Q7 low as abort
        preconds("R7");
        access(4'd15, 1'b1, 8'h57, "R7");
        access(4'd9,  1'b0, 8'h00, "R7");
        for (int i = 1; i < 4; i++) access(4'd15, 1'b1, key_byte(i), "R7");
        preconds("R7");
        access(4'd15, 1'b1, 8'h57, "R7");
        access(4'd15, 1'b0, 8'h17, "R7");
        access(4'd15, 1'b1, 8'h57, "R7");
        access(4'd15, 1'b1, 8'h57, "R7");
        access(4'd14, 1'b0, 8'h00, "R7");
        access(4'd9,  1'b0, 8'h00, "R7");
        access(4'd8,  1'b0, 8'h00, "R7");
        access(4'd13, 1'b0, 8'h00, "R7");
        full_key("R7");
        access(4'd14, 1'b0, 8'h00, "R7");
        access(4'd14, 1'b0, 8'h00, "R7");
        access(4'd8,  1'b0, 8'h00, "R7");
        access(4'd13, 1'b0, 8'h00, "R7");
        full_key("R7");
        do_exit("R7");

        // R8: idle gaps do not move the sequencer
        access(4'd14, 1'b0, 8'h00, "R8");
        repeat (5) @(negedge clk);
        access(4'd8,  1'b0, 8'h00, "R8");
        access(4'd13, 1'b0, 8'h00, "R8");
        for (int i = 0; i < 4; i++) begin
            repeat (3) @(negedge clk);
            chk(ext_enter, 1'b0, "R8", "ext_enter in gap");
            access(4'd15, 1'b1, key_byte(i), "R8");
        end
        do_exit("R8");

        // Random mix scored against the model
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom % 100);
            if (m_ext && r < 25) begin
                do_exit("R9");
            end else if (r < 65) begin
                if (prog < 3) access(pre_code(prog), 1'($urandom % 2), 8'($urandom), "R3");
                else access(4'd15, 1'b1, key_byte(prog - 3), "R3");
            end else if (r < 80 && prog >= 3) begin
                access(4'd15, 1'b1, key_byte(prog - 3) ^ 8'($urandom % 255 + 1), "R5");
            end else if (r < 88) begin
                do_exit("R10");
            end else begin
                access(4'($urandom), 1'($urandom % 2), 8'($urandom), "R7");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule